// File: doc/BRIEF.md
# Oversampled Serial Control Receiver

This block takes slow asynchronous control bytes timed by the tape clock and turns them into configuration settings. A bit lasts a fixed 32 tape-clock periods. A byte is framed by a LOW start bit and a HIGH stop bit. Timing starts on the falling edge of the start bit, and every bit is sampled half a bit period after its boundary. After reset the receiver stays locked. It opens only after the line has been HIGH without a break for ten bit periods.

Two inputs can carry the serial line. One is a dedicated control line. The other is one fixed time-slot inside each 32-clock frame of the record-data stream, with a frame marker giving position 0. Each good byte carries a two-bit tag and a six-bit value. The tag selects one of four configuration registers. The mode register is also decoded into a function select and a filter corner code. A mode byte that sets two mutually exclusive bits is rejected and flagged.

Top module: `ctl_serial_rx`

## Requirements
- R1: After reset, all four configuration registers, `acc_sel`, `corner` and `err_conflict` are 0.
- R2: A bit lasts 32 clocks. Timing starts at the first LOW clock after a HIGH clock. Each bit is sampled 16 clocks after its boundary. Data bits arrive least significant bit first.
- R3: If the start bit reads HIGH at its mid-point sample, the byte is discarded. No register changes, and the receiver keeps accepting later bytes.
- R4: After reset, no byte is accepted until the line has stayed HIGH for 320 consecutive clocks.
- R5: A byte whose stop bit samples LOW is discarded. The receiver then accepts nothing until it sees another unbroken 320-clock HIGH run.
- R6: Byte bits 1:0 form a tag: 0 selects the mode register, 1 the detector register, 2 the gain register and 3 the bias register. Byte bits 7:2 are written to that register, with register bit 0 taken from byte bit 2. No other register changes.
- R7: `acc_sel` is mode bit 0. `corner` is mode bits 2:1, coded 00 floating input, 01 normal, 10 high, 11 very high.
- R8: A mode byte whose value has bit 3 and bit 5 both set leaves the mode register unchanged and sets `err_conflict`. The next accepted mode byte without the conflict clears it. The mode register never holds both bits set.
- R9: With `src_shared` HIGH, the line bit is the `wdat` value at frame position 5, where `frm_start` marks position 0. It is held for the rest of the frame. `wdat` at other positions and `ctl_line` have no effect.
- R10: With `src_shared` LOW, the line is `ctl_line`, and `wdat` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tape clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_line | input | 1 | Dedicated serial control line |
| src_shared | input | 1 | 1: take control bits from the record-data time-slot |
| wdat | input | 1 | Record-data stream |
| frm_start | input | 1 | Marks position 0 of a record-data frame |
| cfg_mode | output | 6 | Mode register |
| cfg_det | output | 6 | Detector register |
| cfg_gain | output | 6 | Gain register |
| cfg_bias | output | 6 | Bias register |
| acc_sel | output | 1 | Function select from mode bit 0 |
| corner | output | 2 | Filter corner code from mode bits 2:1 |
| err_conflict | output | 1 | Forbidden mode combination was received |

## Verification
Rejecting a conflicting mode write and updating the error flag happen on the same accepted byte, in the same cycle. Ending a framing error and re-arming the lock counter also happen in one cycle. The bench sends a conflicting mode byte and checks in one sample that the mode register kept its old value while the flag rose. A following clean mode byte must change the register and clear the flag together. For the framing case, a byte that arrives right after a bad stop bit must be ignored, and only a full HIGH run re-opens the receiver.

// File: rtl/ctl_rx_pkg.sv
package ctl_rx_pkg;
  typedef enum logic [2:0] {
    RX_LOCK  = 3'd0,
    RX_IDLE  = 3'd1,
    RX_START = 3'd2,
    RX_DATA  = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  typedef enum logic [1:0] {
    CORNER_FLOAT  = 2'd0,
    CORNER_NORMAL = 2'd1,
    CORNER_HIGH   = 2'd2,
    CORNER_VHIGH  = 2'd3
  } corner_e;

  localparam int TAG_BITS = 2;
  localparam int NUM_REGS = 2 ** TAG_BITS;
  localparam int MODE_TAG = 0;
  localparam int EXCL_A   = 3;
  localparam int EXCL_B   = 5;
endpackage

// File: rtl/ctl_rx_slot.sv
module ctl_rx_slot #(
  parameter int FRAME_CLKS = 32,
  parameter int SLOT_POS   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic wdat,
  output logic slot_bit
);
  localparam int POS_W = $clog2(FRAME_CLKS);

  logic [POS_W-1:0] pos_q, pos_d, pos_now;
  logic             bit_q, bit_d;

  always_comb begin
    pos_now = frm_start ? '0 : pos_q;
    pos_d   = (pos_now == POS_W'(FRAME_CLKS - 1)) ? '0 : pos_now + 1'b1;
    bit_d   = (pos_now == POS_W'(SLOT_POS)) ? wdat : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      bit_q <= 1'b1;
    end else begin
      pos_q <= pos_d;
      bit_q <= bit_d;
    end
  end

  assign slot_bit = bit_q;
endmodule

// File: rtl/ctl_rx_frame.sv
module ctl_rx_frame
  import ctl_rx_pkg::*;
#(
  parameter int BIT_CLKS  = 32,
  parameter int INIT_BITS = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_i,
  output logic                 byte_vld,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int HALF      = BIT_CLKS / 2;
  localparam int INIT_CLKS = INIT_BITS * BIT_CLKS;
  localparam int CNT_W     = $clog2(BIT_CLKS + 1);
  localparam int RUN_W     = $clog2(INIT_CLKS);
  localparam int IDX_W     = $clog2(DATA_BITS);

  rx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [RUN_W-1:0]     run_q, run_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DATA_BITS-1:0] shf_q, shf_d;
  logic [DATA_BITS-1:0] out_q, out_d;
  logic                 vld_q, vld_d;
  logic                 line_q;
  logic                 sample;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    out_d   = out_q;
    vld_d   = 1'b0;
    sample  = (state_q == RX_START) ? (cnt_q == CNT_W'(HALF))
                                    : (cnt_q == CNT_W'(BIT_CLKS));
    unique case (state_q)
      RX_LOCK: begin
        if (!line_i) begin
          run_d = '0;
        end else if (run_q == RUN_W'(INIT_CLKS - 1)) begin
          run_d   = '0;
          state_d = RX_IDLE;
        end else begin
          run_d = run_q + 1'b1;
        end
      end
      RX_IDLE: begin
        if (!line_i && line_q) begin
          state_d = RX_START;
          cnt_d   = CNT_W'(1);
        end
      end
      RX_START: begin
        cnt_d = cnt_q + 1'b1;
        if (sample) begin
          if (line_i) begin
            state_d = RX_IDLE;
          end else begin
            state_d = RX_DATA;
            cnt_d   = CNT_W'(1);
            idx_d   = '0;
          end
        end
      end
      RX_DATA: begin
        cnt_d = cnt_q + 1'b1;
        if (sample) begin
          shf_d = {line_i, shf_q[DATA_BITS-1:1]};
          cnt_d = CNT_W'(1);
          if (idx_q == IDX_W'(DATA_BITS - 1)) state_d = RX_STOP;
          else                                idx_d   = idx_q + 1'b1;
        end
      end
      RX_STOP: begin
        cnt_d = cnt_q + 1'b1;
        if (sample) begin
          if (line_i) begin
            vld_d   = 1'b1;
            out_d   = shf_q;
            state_d = RX_IDLE;
          end else begin
            run_d   = '0;
            state_d = RX_LOCK;
          end
        end
      end
      default: state_d = RX_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_LOCK;
      cnt_q   <= '0;
      run_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      out_q   <= '0;
      vld_q   <= 1'b0;
      line_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      out_q   <= out_d;
      vld_q   <= vld_d;
      line_q  <= line_i;
    end
  end

  assign byte_vld = vld_q;
  assign byte_o   = out_q;
endmodule

// File: rtl/ctl_rx_regs.sv
module ctl_rx_regs
  import ctl_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int VAL_W    = DATA_BITS - TAG_BITS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            byte_vld,
  input  logic [DATA_BITS-1:0]            byte_i,
  output logic [NUM_REGS-1:0][VAL_W-1:0]  cfg_q,
  output logic                            err_q
);
  logic [TAG_BITS-1:0] tag;
  logic [VAL_W-1:0]    val;
  logic                clash;
  logic [NUM_REGS-1:0] wr_en;
  logic                err_d;

  always_comb begin
    tag   = byte_i[TAG_BITS-1:0];
    val   = byte_i[DATA_BITS-1:TAG_BITS];
    clash = (tag == TAG_BITS'(MODE_TAG)) && val[EXCL_A] && val[EXCL_B];
    err_d = err_q;
    if (byte_vld && (tag == TAG_BITS'(MODE_TAG))) err_d = clash;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign wr_en[g] = byte_vld && (tag == TAG_BITS'(g)) && !((g == MODE_TAG) && clash);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q[g] <= '0;
      else if (wr_en[g]) cfg_q[g] <= val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx
  import ctl_rx_pkg::*;
#(
  parameter int BIT_CLKS  = 32,
  parameter int INIT_BITS = 10,
  parameter int DATA_BITS = 8,
  parameter int SLOT_POS  = 5,
  localparam int VAL_W    = DATA_BITS - TAG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_line,
  input  logic             src_shared,
  input  logic             wdat,
  input  logic             frm_start,
  output logic [VAL_W-1:0] cfg_mode,
  output logic [VAL_W-1:0] cfg_det,
  output logic [VAL_W-1:0] cfg_gain,
  output logic [VAL_W-1:0] cfg_bias,
  output logic             acc_sel,
  output logic [1:0]       corner,
  output logic             err_conflict
);
  logic                           slot_bit;
  logic                           rx_line;
  logic                           byte_vld;
  logic [DATA_BITS-1:0]           rx_byte;
  logic [NUM_REGS-1:0][VAL_W-1:0] cfg;
  corner_e                        corner_sel;

  ctl_rx_slot #(.FRAME_CLKS(BIT_CLKS), .SLOT_POS(SLOT_POS)) u_slot (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .wdat(wdat), .slot_bit(slot_bit)
  );

  assign rx_line = src_shared ? slot_bit : ctl_line;

  ctl_rx_frame #(.BIT_CLKS(BIT_CLKS), .INIT_BITS(INIT_BITS), .DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line), .byte_vld(byte_vld), .byte_o(rx_byte)
  );

  ctl_rx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_i(rx_byte),
    .cfg_q(cfg), .err_q(err_conflict)
  );

  assign cfg_mode   = cfg[0];
  assign cfg_det    = cfg[1];
  assign cfg_gain   = cfg[2];
  assign cfg_bias   = cfg[3];
  assign acc_sel    = cfg_mode[0];
  assign corner_sel = corner_e'(cfg_mode[2:1]);
  assign corner     = corner_sel;
endmodule

// File: rtl/ctl_serial_rx_chk.sv
module ctl_serial_rx_chk #(
  parameter int VAL_W     = 6,
  parameter int INIT_CLKS = 320
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_line,
  input logic             byte_vld,
  input logic [VAL_W-1:0] cfg_mode,
  input logic [VAL_W-1:0] cfg_det,
  input logic [VAL_W-1:0] cfg_gain,
  input logic [VAL_W-1:0] cfg_bias,
  input logic             err
);
  logic [15:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != '1)    since_rst <= since_rst + 1'b1;
  end

  // R4: no byte before the initial HIGH run can have completed
  a_r4_init_wait: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (since_rst > 16'(INIT_CLKS)));

  // R5: an accepted byte had a HIGH stop sample
  a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(rx_line));

  // R6: registers only move after an accepted byte
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable({cfg_mode, cfg_det, cfg_gain, cfg_bias}));

  // R8: exclusive mode bits never stored together
  a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_mode[3] && cfg_mode[5]));

  // R8: flag rises only in answer to a received byte
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(byte_vld));
endmodule

bind ctl_serial_rx ctl_serial_rx_chk #(.VAL_W(VAL_W), .INIT_CLKS(INIT_BITS * BIT_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .byte_vld(byte_vld),
  .cfg_mode(cfg_mode), .cfg_det(cfg_det), .cfg_gain(cfg_gain), .cfg_bias(cfg_bias),
  .err(err_conflict)
);

// File: tb/ctl_serial_rx_test.sv
module ctl_serial_rx_test;
  localparam int BITC = 32;
  localparam int SLOT = 5;

  logic       clk = 1'b0;
  logic       rst_n, ctl_line, src_shared, wdat, frm_start;
  logic [5:0] cfg_mode, cfg_det, cfg_gain, cfg_bias;
  logic       acc_sel, err_conflict;
  logic [1:0] corner;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ctl_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .ctl_line(ctl_line), .src_shared(src_shared),
    .wdat(wdat), .frm_start(frm_start), .cfg_mode(cfg_mode), .cfg_det(cfg_det),
    .cfg_gain(cfg_gain), .cfg_bias(cfg_bias), .acc_sel(acc_sel), .corner(corner),
    .err_conflict(err_conflict)
  );

  function automatic logic [7:0] mk(input logic [1:0] tag, input logic [5:0] val);
    return {val, tag};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_send(input logic [7:0] b, input logic stop_val);
    ctl_line = 1'b0; idle(BITC);
    for (int i = 0; i < 8; i++) begin
      ctl_line = b[i]; idle(BITC);
    end
    ctl_line = stop_val; idle(BITC);
    ctl_line = 1'b1; idle(20);
  endtask

  task automatic frame(input logic v);
    for (int p = 0; p < BITC; p++) begin
      frm_start = (p == 0);
      wdat      = (p == SLOT) ? v : ~v;
      @(negedge clk);
    end
    frm_start = 1'b0;
  endtask

  task automatic sh_send(input logic [7:0] b);
    frame(1'b0);
    for (int i = 0; i < 8; i++) frame(b[i]);
    frame(1'b1);
    frame(1'b1);
    frame(1'b1);
  endtask

  task automatic t_reset;
    check("R1 mode", cfg_mode, 0);
    check("R1 det", cfg_det, 0);
    check("R1 gain", cfg_gain, 0);
    check("R1 bias", cfg_bias, 0);
    check("R1 flags", {acc_sel, corner, err_conflict}, 0);
  endtask

  task automatic t_locked;
    idle(40);
    ctl_send(mk(2'd0, 6'h03), 1'b1);
    check("R4 early byte ignored", cfg_mode, 0);
    idle(340);
  endtask

  task automatic t_decode;
    ctl_send(mk(2'd0, 6'b000011), 1'b1);
    check("R2 R6 mode write", cfg_mode, 6'h03);
    check("R7 acc_sel", acc_sel, 1);
    check("R7 corner normal", corner, 2'b01);
    ctl_send(mk(2'd1, 6'h2A), 1'b1);
    check("R6 det write", cfg_det, 6'h2A);
    check("R6 mode untouched", cfg_mode, 6'h03);
    ctl_send(mk(2'd2, 6'h15), 1'b1);
    check("R6 gain write", cfg_gain, 6'h15);
    ctl_send(mk(2'd3, 6'h3C), 1'b1);
    check("R6 bias write", cfg_bias, 6'h3C);
    check("R6 others untouched", {cfg_det, cfg_gain}, {6'h2A, 6'h15});
    ctl_send(mk(2'd0, 6'b000100), 1'b1);
    check("R7 corner high", corner, 2'b10);
    check("R7 acc_sel low", acc_sel, 0);
    ctl_send(mk(2'd0, 6'b000110), 1'b1);
    check("R7 corner very high", corner, 2'b11);
  endtask

  task automatic t_glitch;
    ctl_line = 1'b0; idle(8);
    ctl_line = 1'b1; idle(60);
    check("R3 glitch ignored", {cfg_mode, cfg_det}, {6'b000110, 6'h2A});
    ctl_send(mk(2'd1, 6'h11), 1'b1);
    check("R3 receiver still live", cfg_det, 6'h11);
  endtask

  task automatic t_conflict;
    ctl_send(mk(2'd0, 6'b101000), 1'b1);
    check("R8 conflict rejected", cfg_mode, 6'b000110);
    check("R8 flag set", err_conflict, 1);
    ctl_send(mk(2'd0, 6'b001001), 1'b1);
    check("R8 clean mode write", cfg_mode, 6'b001001);
    check("R8 flag cleared", err_conflict, 0);
  endtask

  task automatic t_framing;
    ctl_send(mk(2'd2, 6'h07), 1'b0);
    check("R5 bad stop ignored", cfg_gain, 6'h15);
    idle(20);
    ctl_send(mk(2'd2, 6'h08), 1'b1);
    check("R5 relock required", cfg_gain, 6'h15);
    idle(340);
    ctl_send(mk(2'd2, 6'h08), 1'b1);
    check("R5 accepted after relock", cfg_gain, 6'h08);
  endtask

  task automatic t_shared;
    wdat = 1'b1; idle(2);
    src_shared = 1'b1; idle(1);
    ctl_line = 1'b0;
    frame(1'b1);
    frame(1'b1);
    sh_send(mk(2'd3, 6'h21));
    check("R9 slot byte", cfg_bias, 6'h21);
    check("R9 ctl_line ignored", cfg_mode, 6'b001001);
  endtask

  task automatic t_ctl_again;
    ctl_line = 1'b1; idle(2);
    src_shared = 1'b0; wdat = 1'b0; idle(40);
    ctl_send(mk(2'd1, 6'h3F), 1'b1);
    check("R10 ctl byte with wdat low", cfg_det, 6'h3F);
    check("R10 bias unchanged", cfg_bias, 6'h21);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_line = 1'b1; src_shared = 1'b0; wdat = 1'b1; frm_start = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_locked();
    t_decode();
    t_glitch();
    t_conflict();
    t_framing();
    t_shared();
    t_ctl_again();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule